// File: doc/BRIEF.md
# RTC Interrupt Flag and Status Register

This block keeps the interrupt side of a real-time clock. Three event sources feed it as single-cycle pulses: the end of a time update, an alarm match and a periodic tick from the divider chain. Each pulse latches a sticky flag. A control byte written by the host holds one enable per source, together with several mode bits that other parts of the clock use. The block combines every flag with its own enable into a single interrupt flag, and drives an active-low interrupt line from that flag.

The host reads three byte-wide registers through one select field: control, flags and status. Reading the flag register returns its current value and clears all three flags at the next clock edge, which releases the interrupt line. An event that arrives in the same cycle as that read is not lost. The status register always shows its valid-RAM-and-time bit as set. A system reset clears the enables, the square-wave enable and the flags. It keeps the set-mode, data-mode, hour-format and daylight-saving bits.

Top module: `rtc_irq_status`

## Requirements
- R1: With `rd_sel`=1 the flag byte reads bit 7 = combined interrupt flag, bit 6 = periodic flag, bit 5 = alarm flag, bit 4 = update-ended flag, and bits 3..0 = 0.
- R2: With `rd_sel`=0 the host writes and reads the control byte: bit 7 set-mode, bit 6 periodic enable, bit 5 alarm enable, bit 4 update enable, bit 3 square-wave enable, bit 2 data mode, bit 1 hour format, bit 0 daylight-saving enable. A write takes effect at the next clock edge.
- R3: A pulse on an event input sets its flag at the next clock edge, whether or not its enable is set.
- R4: The combined flag is 1 exactly when at least one flag and its own enable are both 1, and `irq_n` is 0 exactly when the combined flag is 1.
- R5: A read of the flag register returns the value before clearing. All flags are 0 after the following clock edge, and `irq_n` returns to 1.
- R6: An event pulse in the same cycle as a clearing flag read leaves its flag set after that edge.
- R7: Reset (`rst_n`=0) clears the three interrupt enables, the square-wave enable and all flags. It leaves set-mode, data mode, hour format and daylight-saving enable unchanged.
- R8: A control write that takes set-mode from 0 to 1 stores the update enable as 0 whatever the written bit 4. When set-mode is already 1, bit 4 is stored as written.
- R9: With `rd_sel`=2 the status register reads 0x80. With `rd_sel`=3 the read data is 0x00.
- R10: Writes with `wr_sel`=1 (flags) or `wr_sel`=2 (status) change neither the flags nor the control byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_update | input | 1 | Update-ended event pulse |
| evt_alarm | input | 1 | Alarm-match event pulse |
| evt_periodic | input | 1 | Periodic tick pulse |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write register select (0 control, 1 flags, 2 status) |
| wr_data | input | 8 | Host write data |
| rd_en | input | 1 | Host read strobe (a flag read clears the flags) |
| rd_sel | input | 2 | Read register select (0 control, 1 flags, 2 status, 3 none) |
| rd_data | output | 8 | Read data for the selected register, combinational |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its default parameters: a byte-wide register file with three event sources, which is the only layout the host software expects. At that size every enable and flag combination can be reached in a few cycles. The bench can therefore drive a clearing read and a new event into the same edge, and take set-mode across its 0-to-1 step with the update enable both set and cleared. It also asserts reset while modes and flags are loaded, then reads back which bits survived.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int REG_W     = 8;
    localparam int SEL_W     = 2;
    localparam int NUM_SRC   = 3;
    localparam int FLAG_BASE = 4;             // flag of source i sits at bit FLAG_BASE+i
    localparam int IRQF_BIT  = REG_W - 1;
    localparam int VALID_BIT = REG_W - 1;

    // source indices, ordered to match the flag byte bit positions
    localparam int SRC_UPD = 0;
    localparam int SRC_ALM = 1;
    localparam int SRC_PER = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_FLAG = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // control byte, bit 7 first
    typedef struct packed {
        logic set_mode;
        logic per_en;
        logic alm_en;
        logic upd_en;
        logic sqw_en;
        logic bin_mode;
        logic hr24;
        logic dst_en;
    } ctrl_t;

    // bits cleared by reset
    typedef struct packed {
        logic per_en;
        logic alm_en;
        logic upd_en;
        logic sqw_en;
    } ctrl_en_t;

    // bits kept through reset
    typedef struct packed {
        logic set_mode;
        logic bin_mode;
        logic hr24;
        logic dst_en;
    } ctrl_mode_t;

endpackage

// File: rtl/rtc_irq_ctrl_reg.sv
module rtc_irq_ctrl_reg
    import rtc_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_stb,
    input  ctrl_t wr_data,
    output ctrl_t ctrl_q
);

    typedef struct packed {
        ctrl_en_t   en;
        ctrl_mode_t mode;
    } ctrl_state_t;

    ctrl_state_t st_d;
    ctrl_en_t    en_q;
    ctrl_mode_t  mode_q;
    logic        set_rise;

    always_comb begin
        st_d.en   = en_q;
        st_d.mode = mode_q;
        set_rise  = wr_stb && wr_data.set_mode && !mode_q.set_mode;
        if (wr_stb) begin
            st_d.en.per_en     = wr_data.per_en;
            st_d.en.alm_en     = wr_data.alm_en;
            st_d.en.upd_en     = wr_data.upd_en && !set_rise;
            st_d.en.sqw_en     = wr_data.sqw_en;
            st_d.mode.set_mode = wr_data.set_mode;
            st_d.mode.bin_mode = wr_data.bin_mode;
            st_d.mode.hr24     = wr_data.hr24;
            st_d.mode.dst_en   = wr_data.dst_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= st_d.en;
        end
    end

    // mode bits survive reset by design
    always_ff @(posedge clk) begin
        mode_q <= st_d.mode;
    end

    always_comb begin
        ctrl_q.set_mode = mode_q.set_mode;
        ctrl_q.per_en   = en_q.per_en;
        ctrl_q.alm_en   = en_q.alm_en;
        ctrl_q.upd_en   = en_q.upd_en;
        ctrl_q.sqw_en   = en_q.sqw_en;
        ctrl_q.bin_mode = mode_q.bin_mode;
        ctrl_q.hr24     = mode_q.hr24;
        ctrl_q.dst_en   = mode_q.dst_en;
    end

endmodule

// File: rtl/rtc_irq_flag_bank.sv
module rtc_irq_flag_bank #(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               clr,
    input  logic [NUM_SRC-1:0] en,
    output logic [NUM_SRC-1:0] flag_q,
    output logic               irqf
);

    logic [NUM_SRC-1:0] flag_d;
    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        always_comb begin
            // a new event wins over a clearing read in the same cycle
            flag_d[i] = evt[i] | (flag_q[i] & ~clr);
            hit[i]    = flag_q[i] & en[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign irqf = |hit;

endmodule

// File: rtl/rtc_irq_read_mux.sv
module rtc_irq_read_mux
    import rtc_irq_pkg::*;
#(
    parameter int NUM_SRC = rtc_irq_pkg::NUM_SRC
) (
    input  logic [SEL_W-1:0]   sel,
    input  ctrl_t              ctrl,
    input  logic [NUM_SRC-1:0] flags,
    input  logic               irqf,
    output logic [REG_W-1:0]   data
);

    logic [REG_W-1:0] flag_byte;
    logic [REG_W-1:0] stat_byte;

    always_comb begin
        flag_byte = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            flag_byte[FLAG_BASE+i] = flags[i];
        end
        flag_byte[IRQF_BIT] = irqf;
        stat_byte = '0;
        stat_byte[VALID_BIT] = 1'b1;
        case (reg_sel_e'(sel))
            SEL_CTRL: data = ctrl;
            SEL_FLAG: data = flag_byte;
            SEL_STAT: data = stat_byte;
            default:  data = '0;
        endcase
    end

endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
    import rtc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_update,
    input  logic             evt_alarm,
    input  logic             evt_periodic,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_n
);

    ctrl_t              ctrl;
    logic [NUM_SRC-1:0] evt_vec;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] flag_vec;
    logic               irqf;
    logic               ctrl_wr;
    logic               flag_clr;

    always_comb begin
        evt_vec          = '0;
        evt_vec[SRC_UPD] = evt_update;
        evt_vec[SRC_ALM] = evt_alarm;
        evt_vec[SRC_PER] = evt_periodic;
        en_vec           = '0;
        en_vec[SRC_UPD]  = ctrl.upd_en;
        en_vec[SRC_ALM]  = ctrl.alm_en;
        en_vec[SRC_PER]  = ctrl.per_en;
        ctrl_wr          = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
        flag_clr         = rd_en && (reg_sel_e'(rd_sel) == SEL_FLAG);
    end

    rtc_irq_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (ctrl_wr),
        .wr_data (ctrl_t'(wr_data)),
        .ctrl_q  (ctrl)
    );

    rtc_irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_vec),
        .clr    (flag_clr),
        .en     (en_vec),
        .flag_q (flag_vec),
        .irqf   (irqf)
    );

    rtc_irq_read_mux #(.NUM_SRC(NUM_SRC)) u_rmux (
        .sel   (rd_sel),
        .ctrl  (ctrl),
        .flags (flag_vec),
        .irqf  (irqf),
        .data  (rd_data)
    );

    assign irq_n = ~irqf;

endmodule

// File: rtl/rtc_irq_status_chk.sv
module rtc_irq_status_chk
    import rtc_irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               evt_update,
    input logic               evt_alarm,
    input logic               evt_periodic,
    input logic               wr_en,
    input logic [SEL_W-1:0]   wr_sel,
    input logic [REG_W-1:0]   wr_data,
    input logic               rd_en,
    input logic [SEL_W-1:0]   rd_sel,
    input logic [REG_W-1:0]   rd_data,
    input logic               irq_n,
    input logic [NUM_SRC-1:0] flag_vec,
    input logic [NUM_SRC-1:0] en_vec
);

    logic [NUM_SRC-1:0] evt_now;
    assign evt_now = {evt_periodic, evt_alarm, evt_update};

    // R1: unused low nibble of the flag byte
    assert_flag_low_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_FLAG) |-> (rd_data[FLAG_BASE-1:0] == '0));

    // R4: read-back combined flag agrees with the interrupt pin
    assert_irq_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_FLAG) |-> (rd_data[IRQF_BIT] == !irq_n));

    // R4: pin low needs some flag with its enable
    assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((flag_vec & en_vec) != '0));

    // R3: an event sets its flag at the next edge
    assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_alarm |=> flag_vec[SRC_ALM]);

    // R5 and R6: after a clearing read only same-cycle events remain
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == SEL_FLAG) |=> (flag_vec == $past(evt_now)));

    // R8: set-mode rising stores the update enable as zero
    assert_set_kills_upd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL && wr_data[7] &&
         !(rd_sel == SEL_CTRL && rd_data[7])) && (rd_sel == SEL_CTRL)
        |=> !en_vec[SRC_UPD]);

    // R9: status read pattern
    assert_status_const_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_STAT) |-> (rd_data == 8'h80));

    // R10: a write to the flag register never sets a flag
    assert_flag_wr_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_FLAG && evt_now == '0 && flag_vec == '0) |=> (flag_vec == '0));

endmodule

bind rtc_irq_status rtc_irq_status_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_update   (evt_update),
    .evt_alarm    (evt_alarm),
    .evt_periodic (evt_periodic),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .rd_en        (rd_en),
    .rd_sel       (rd_sel),
    .rd_data      (rd_data),
    .irq_n        (irq_n),
    .flag_vec     (flag_vec),
    .en_vec       (en_vec)
);

// File: tb/rtc_irq_status_tb.sv
module rtc_irq_status_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_update = 1'b0;
    logic       evt_alarm = 1'b0;
    logic       evt_periodic = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] mask;
        string      tag;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    rtc_irq_status u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_update   (evt_update),
        .evt_alarm    (evt_alarm),
        .evt_periodic (evt_periodic),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .rd_en        (rd_en),
        .rd_sel       (rd_sel),
        .rd_data      (rd_data),
        .irq_n        (irq_n)
    );

    // monitor: compares each read against the queued expectation
    always @(negedge clk) begin
        if (rd_en && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if ((rd_data & it.mask) !== (it.exp & it.mask)) begin
                n_bad++;
                $display("FAIL %s: read actual 0x%02h expected 0x%02h (mask 0x%02h)",
                         it.tag, rd_data, it.exp, it.mask);
            end
        end
    end

    task automatic do_read(input logic [1:0] sel, input logic [7:0] exp,
                           input logic [7:0] mask, input string tag,
                           input logic [2:0] evts = 3'b000);
        item_t it;
        @(posedge clk); #1;
        it.exp = exp; it.mask = mask; it.tag = tag;
        sb_q.push_back(it);
        rd_en = 1'b1; rd_sel = sel;
        {evt_periodic, evt_alarm, evt_update} = evts;
        @(posedge clk); #1;
        rd_en = 1'b0;
        {evt_periodic, evt_alarm, evt_update} = 3'b000;
    endtask

    task automatic do_write(input logic [1:0] sel, input logic [7:0] data);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // evts order: {periodic, alarm, update}
    task automatic pulse(input logic [2:0] evts);
        @(posedge clk); #1;
        {evt_periodic, evt_alarm, evt_update} = evts;
        @(posedge clk); #1;
        {evt_periodic, evt_alarm, evt_update} = 3'b000;
    endtask

    task automatic check_irq(input logic exp, input string tag);
        @(negedge clk);
        n_cmp++;
        if (irq_n !== exp) begin
            n_bad++;
            $display("FAIL %s: irq_n actual %0b expected %0b", tag, irq_n, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R7 reset state
        do_read(2'd1, 8'h00, 8'hFF, "R7 flags after reset");
        do_read(2'd0, 8'h00, 8'h78, "R7 enables after reset");
        check_irq(1'b1, "R7 irq idle after reset");

        // R2 control layout
        do_write(2'd0, 8'h5A);
        do_read(2'd0, 8'h5A, 8'hFF, "R2 control readback 0x5A");
        do_write(2'd0, 8'h00);
        do_read(2'd0, 8'h00, 8'hFF, "R2 control readback 0x00");

        // R3 flags set with enables off, R1 layout
        pulse(3'b100);
        check_irq(1'b1, "R4 periodic flag without enable");
        do_read(2'd1, 8'h40, 8'hFF, "R3 periodic flag R1 bit6");
        do_read(2'd1, 8'h00, 8'hFF, "R5 flags cleared by read");
        pulse(3'b011);
        do_read(2'd1, 8'h30, 8'hFF, "R3 alarm+update R1 bits5,4");
        do_read(2'd1, 8'h00, 8'hFF, "R5 flags cleared again");

        // R4 alarm enabled
        do_write(2'd0, 8'h20);
        pulse(3'b010);
        check_irq(1'b0, "R4 alarm with enable");
        do_read(2'd1, 8'hA0, 8'hFF, "R4 combined flag R1 bit7");
        check_irq(1'b1, "R5 irq released after read");

        // R4 only matching pair raises the line
        do_write(2'd0, 8'h10);
        pulse(3'b100);
        check_irq(1'b1, "R4 periodic flag with update enable only");
        pulse(3'b001);
        check_irq(1'b0, "R4 update flag with update enable");
        do_read(2'd1, 8'hD0, 8'hFF, "R4 combined with two flags");
        check_irq(1'b1, "R5 irq released");

        // R6 event during clearing read
        do_read(2'd1, 8'h00, 8'hFF, "R6 read value before event", 3'b010);
        do_read(2'd1, 8'h20, 8'hFF, "R6 event kept through clear");
        pulse(3'b001);
        do_read(2'd1, 8'h90, 8'hFF, "R5 pre-clear value", 3'b001);
        check_irq(1'b0, "R6 update event kept, irq stays low");
        do_read(2'd1, 8'h90, 8'hFF, "R6 update flag kept");

        // R8 set-mode rising clears update enable
        do_write(2'd0, 8'h90);
        do_read(2'd0, 8'h80, 8'hFF, "R8 upd enable cleared on set rise");
        do_write(2'd0, 8'h90);
        do_read(2'd0, 8'h90, 8'hFF, "R8 upd enable kept when set already 1");
        do_write(2'd0, 8'h10);
        do_read(2'd0, 8'h10, 8'hFF, "R8 set cleared, upd enable written");

        // R10 and R9
        do_write(2'd1, 8'hFF);
        do_read(2'd1, 8'h00, 8'hFF, "R10 flag write ignored");
        pulse(3'b100);
        do_write(2'd1, 8'h00);
        do_read(2'd1, 8'h40, 8'hFF, "R10 flag write cannot clear");
        do_write(2'd2, 8'h00);
        do_read(2'd2, 8'h80, 8'hFF, "R9 status reads 0x80");
        do_read(2'd0, 8'h10, 8'hFF, "R10 control untouched by other writes");
        do_read(2'd3, 8'h00, 8'hFF, "R9 unused select reads 0");

        // R7 reset keeps modes
        do_write(2'd0, 8'hFF);
        do_read(2'd0, 8'hEF, 8'hFF, "R8 set rise with all bits");
        pulse(3'b111);
        check_irq(1'b0, "R4 all flags enabled");
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        check_irq(1'b1, "R7 irq after reset");
        do_read(2'd0, 8'h87, 8'hFF, "R7 modes kept, enables cleared");
        do_read(2'd1, 8'h00, 8'hFF, "R7 flags cleared");

        @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule